// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Controller

This block is the digital half of a serial 8-bit successive-approximation converter that has a multiplexed analog input. The comparator, the trial DAC, the sample-and-hold and the input multiplexer stay outside the block and are reached only through ports. A host lowers chip select and sends a start bit, then a mode bit and a channel bit, on the serial input. The block then asks for one acquisition period and runs a binary search with one decision per serial clock. It places each trial code on the DAC port and reads a single comparator bit back.

Each decision goes onto the serial output as soon as it is made, most significant first. The finished word then follows least significant first. The output is high impedance while the host is still addressing the part, so the input and output pins can share one wire. Raising chip select at any time ends the transaction at once.

Top module: `sar_serial_ctrl`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block returns to idle: sdo_oe=0, sdo=0, smp_en=0, dac_code=0, mux_sgl=0 and mux_chan=0.
- R2: With cs_n low and the block waiting, a 0 on sdi at a rising edge is ignored. The first 1 is the start bit. The next rising edge captures mux_sgl (1 = single-ended) and the one after that captures mux_chan. Both hold their values until the next address phase.
- R3: sdo_oe is 0 whenever cs_n is high, while the block waits for a start bit, and during the address and acquisition periods.
- R4: smp_en is 1 for exactly one clock period, the one that begins at the rising edge that captures mux_chan.
- R5: For 8 clock periods after acquisition, dac_code holds the decided bits plus the bit under trial, going from bit 7 down to bit 0. A tried bit is kept when cmp_hi=1 at the end of its period, so an input level v gives a result of v when cmp_hi = (v >= dac_code). dac_code is 0 in every other period.
- R6: Number the rising edges from the one that takes the start bit as edge 0. At the falling edge after edge 3, sdo is a driven 0 null bit. At the falling edge after edge 4+i (i = 0..7), sdo is result bit 7-i.
- R7: At the falling edges after edges 12 to 18, sdo carries result bits 0 to 6 in that order. Bit 7 is not sent again.
- R8: From the falling edge after edge 19 until cs_n goes high, sdo_oe=1 and sdo=0.
- R9: cs_n high at a rising edge ends any transaction. sdo_oe drops as soon as cs_n rises, dac_code and smp_en return to 0, and a new transaction needs a new start bit.
- R10: sdi is ignored outside the three address bits. Toggling it during or after the conversion changes neither the result nor the mux outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; state moves on rising edges, sdo changes on falling edges |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial address input |
| sdo | output | 1 | Serial result output value |
| sdo_oe | output | 1 | Output enable for the shared data pin; 0 means high impedance |
| smp_en | output | 1 | Acquisition strobe to the sample-and-hold |
| mux_sgl | output | 1 | Captured input mode, 1 = single-ended |
| mux_chan | output | MUX_SEL_BITS | Captured channel/polarity select |
| dac_code | output | DATA_W | Trial code to the external DAC |
| cmp_hi | input | 1 | Comparator: 1 when the input is at or above the trial level |

## Verification
The bench models an ideal comparator and converts all-zero, all-one, mid-scale (0x80 and 0x7F) and alternating-bit levels, followed by random levels. The extreme codes show whether every trial bit is kept or dropped. The two mid-scale codes separate a fault in the MSB decision from a fault in the lower bits, and the alternating pattern exposes a wrong bit order in either direction of the output stream. Random sdi noise after the address bits and a random number of leading zeros before the start bit test what the block must ignore. Aborts placed in the address, search, LSB-first and trailing-low periods show that each state returns cleanly to waiting.

// File: rtl/sar_ctrl_pkg.sv
// Shared types for the serial successive-approximation controller.
package sar_ctrl_pkg;
    // Transaction phase; each value spans one or more serial clock periods.
    typedef enum logic [2:0] {
        PH_IDLE,   // waiting for a start bit
        PH_ADDR,   // receiving mode and channel bits
        PH_ACQ,    // one acquisition period
        PH_CONV,   // binary search, one bit per period
        PH_TAIL,   // last MSB-first decision on the wire
        PH_LSB,    // re-sending low bits, LSB first
        PH_DONE    // output held low until deselect
    } phase_e;
endpackage

// File: rtl/sar_seq_fsm.sv
// Phase sequencer: finds the start bit, captures the address bits, then
// steps through acquisition, search and the LSB-first replay.
// Assumes cs_n and sdi are synchronous to the rising edge of clk.
module sar_seq_fsm
    import sar_ctrl_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_BITS = 2,
    parameter int IDX_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sdi,
    output phase_e               phase,
    output logic [IDX_W-1:0]     bit_idx,
    output logic [IDX_W-1:0]     lsb_cnt,
    output logic [ADDR_BITS-1:0] addr_q
);
    localparam int ACNT_W = $clog2(ADDR_BITS + 1);
    localparam logic [IDX_W-1:0]  IDX_TOP   = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0]  LSB_LAST  = IDX_W'(DATA_W - 2);
    localparam logic [ACNT_W-1:0] ACNT_LAST = ACNT_W'(ADDR_BITS - 1);

    logic [ACNT_W-1:0] acnt;

    // Advance the phase and its counters once per rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_idx <= '0;
            lsb_cnt <= '0;
            acnt    <= '0;
        end else if (cs_n) begin
            phase <= PH_IDLE;
            acnt  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (sdi) begin
                        phase <= PH_ADDR;
                        acnt  <= '0;
                    end
                end
                PH_ADDR: begin
                    acnt <= acnt + 1'b1;
                    if (acnt == ACNT_LAST) phase <= PH_ACQ;
                end
                PH_ACQ: begin
                    phase   <= PH_CONV;
                    bit_idx <= IDX_TOP;
                end
                PH_CONV: begin
                    if (bit_idx == '0) phase <= PH_TAIL;
                    else               bit_idx <= bit_idx - 1'b1;
                end
                PH_TAIL: begin
                    phase   <= PH_LSB;
                    lsb_cnt <= '0;
                end
                PH_LSB: begin
                    if (lsb_cnt == LSB_LAST) phase <= PH_DONE;
                    else                     lsb_cnt <= lsb_cnt + 1'b1;
                end
                PH_DONE: phase <= PH_DONE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Shift in the address bits, first received bit ending at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (!cs_n && phase == PH_ADDR)
            addr_q <= {addr_q[ADDR_BITS-2:0], sdi};
    end

    // R9: deselect always returns the sequencer to waiting
    p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> phase == PH_IDLE);

    // R5: the search walks down one bit per period
    p_conv_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CONV && bit_idx != '0 && !cs_n)
        |=> (phase == PH_CONV && bit_idx == IDX_W'($past(bit_idx) - 1'b1)));

    // R10: address bits change only during the address phase
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_ADDR) |=> $stable(addr_q));

    // R7: replay counter never passes the last replayed bit
    p_lsb_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lsb_cnt <= LSB_LAST);
endmodule

// File: rtl/sar_search.sv
// Successive-approximation register: forms the trial code and keeps or
// clears each bit from the comparator. Assumes cmp_hi is settled by the
// rising edge that ends each trial period.
module sar_search
    import sar_ctrl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              cmp_hi,
    output logic [DATA_W-1:0] res_q,
    output logic              dec_q,
    output logic [DATA_W-1:0] dac_code
);
    logic [DATA_W-1:0] trial_bit;

    // One-hot mask of the bit under trial.
    always_comb begin
        trial_bit          = '0;
        trial_bit[bit_idx] = 1'b1;
    end

    // Drive the DAC only while searching.
    always_comb begin
        dac_code = (phase == PH_CONV) ? (res_q | trial_bit) : '0;
    end

    // Clear at acquisition, then record one decision per search period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            dec_q <= 1'b0;
        end else if (phase == PH_ACQ) begin
            res_q <= '0;
        end else if (phase == PH_CONV) begin
            res_q[bit_idx] <= cmp_hi;
            dec_q          <= cmp_hi;
        end
    end

    // R8: result is frozen while being replayed and afterwards
    p_res_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LSB || phase == PH_DONE) |=> $stable(res_q));

    // R5: the trial code holds exactly one bit above the kept result
    p_trial_onebit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CONV) |-> ($countones(dac_code & ~res_q) == 1));
endmodule

// File: rtl/sar_out_ser.sv
// Serial output stage: picks the bit for the current phase and updates the
// shared data pin on the falling edge. The enable is gated by cs_n without
// a clock so deselect releases the wire at once.
module sar_out_ser
    import sar_ctrl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  phase_e            phase,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [IDX_W-1:0]  lsb_cnt,
    input  logic [DATA_W-1:0] res_q,
    input  logic              dec_q,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DATA_W - 1);

    logic nxt_bit, nxt_oe;
    logic bit_q, oe_q;

    // Choose the value the wire should carry in the current phase.
    always_comb begin
        nxt_bit = 1'b0;
        nxt_oe  = 1'b0;
        case (phase)
            PH_CONV: begin
                nxt_oe  = 1'b1;
                nxt_bit = (bit_idx == IDX_TOP) ? 1'b0 : dec_q;
            end
            PH_TAIL: begin
                nxt_oe  = 1'b1;
                nxt_bit = dec_q;
            end
            PH_LSB: begin
                nxt_oe  = 1'b1;
                nxt_bit = res_q[lsb_cnt];
            end
            PH_DONE: nxt_oe = 1'b1;
            default: nxt_oe = 1'b0;
        endcase
    end

    // Launch the output bit on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            bit_q <= nxt_bit;
            oe_q  <= nxt_oe;
        end
    end

    assign sdo_oe = oe_q & ~cs_n;
    assign sdo    = bit_q & sdo_oe;

    // R3: the pin stays released while waiting, addressing and acquiring
    p_release_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE || phase == PH_ADDR || phase == PH_ACQ) |-> !sdo_oe);

    // R8: after the replay the pin is driven low while selected
    p_low_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE && !cs_n) |-> (sdo_oe && !sdo));
endmodule

// File: rtl/sar_serial_ctrl.sv
// Top of the serial successive-approximation controller. Connects the
// sequencer, search register and output stage, and decodes the captured
// address into mode and channel outputs. Assumes one external comparator
// whose cmp_hi follows dac_code within one clock period.
module sar_serial_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int MUX_SEL_BITS = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    sdi,
    output logic                    sdo,
    output logic                    sdo_oe,
    output logic                    smp_en,
    output logic                    mux_sgl,
    output logic [MUX_SEL_BITS-1:0] mux_chan,
    output logic [DATA_W-1:0]       dac_code,
    input  logic                    cmp_hi
);
    localparam int ADDR_BITS = 1 + MUX_SEL_BITS;
    localparam int IDX_W     = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    phase_e                phase;
    logic [IDX_W-1:0]      bit_idx;
    logic [IDX_W-1:0]      lsb_cnt;
    logic [ADDR_BITS-1:0]  addr_q;
    logic [DATA_W-1:0]     res_q;
    logic                  dec_q;

    sar_seq_fsm #(
        .DATA_W(DATA_W), .ADDR_BITS(ADDR_BITS), .IDX_W(IDX_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi),
        .phase(phase), .bit_idx(bit_idx), .lsb_cnt(lsb_cnt), .addr_q(addr_q)
    );

    sar_search #(
        .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_search (
        .clk(clk), .rst_n(rst_n), .phase(phase), .bit_idx(bit_idx),
        .cmp_hi(cmp_hi), .res_q(res_q), .dec_q(dec_q), .dac_code(dac_code)
    );

    sar_out_ser #(
        .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .phase(phase),
        .bit_idx(bit_idx), .lsb_cnt(lsb_cnt), .res_q(res_q), .dec_q(dec_q),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    // Decode the address: first bit is mode, the rest select the channel.
    assign mux_sgl  = addr_q[ADDR_BITS-1];
    assign mux_chan = addr_q[MUX_SEL_BITS-1:0];
    assign smp_en   = (phase == PH_ACQ);

    // R4: the acquisition strobe lasts a single period
    p_smp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_en |=> !smp_en);

    // R5: no trial code reaches the DAC outside the search
    p_dac_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_CONV) |-> (dac_code == '0));
endmodule

// File: tb/test_sar_serial_ctrl.sv
module test_sar_serial_ctrl;
    logic       clk = 1'b0;
    logic       rst_n, cs_n, sdi;
    logic [7:0] vin;
    logic       sdo, sdo_oe, smp_en, mux_sgl;
    logic [0:0] mux_chan;
    logic [7:0] dac_code;
    logic       cmp_hi;
    int         n_tests = 0;
    int         n_fail  = 0;

    always #2 clk = ~clk;

    // Ideal comparator from the modelled input level.
    assign cmp_hi = (vin >= dac_code);

    sar_serial_ctrl i_sar_serial_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .smp_en(smp_en), .mux_sgl(mux_sgl),
        .mux_chan(mux_chan), .dac_code(dac_code), .cmp_hi(cmp_hi)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Expected {oe, bit} at the falling edge after rising edge k (R3,R6,R7,R8).
    function automatic logic [1:0] exp_slot(input int k, input logic [7:0] v);
        if (k <= 2)       return 2'b00;
        else if (k == 3)  return 2'b10;
        else if (k <= 11) return {1'b1, v[11-k]};
        else if (k <= 18) return {1'b1, v[k-12]};
        else              return 2'b10;
    endfunction

    function automatic string slot_req(input int k);
        if (k <= 2)       return "R3";
        else if (k <= 11) return "R6";
        else if (k <= 18) return "R7";
        else              return "R8";
    endfunction

    // Expected DAC code while bit idx is under trial (R5).
    function automatic logic [7:0] exp_trial(input int idx, input logic [7:0] v);
        logic [7:0] hi = 8'hFF << (idx + 1);
        return (v & hi) | (8'd1 << idx);
    endfunction

    // One transaction; abort_at < 0 means run to completion.
    task automatic run_conv(input logic [7:0] v, input logic sgl, input logic ch,
                            input int lead, input int abort_at);
        vin = v;
        @(posedge clk); #1;
        cs_n = 1'b0;
        sdi  = 1'b0;
        for (int i = 0; i < lead; i++) begin
            @(posedge clk); #1;
            chk("R2", "zeros before start ignored, oe", sdo_oe, 0);
            chk("R3", "no strobe while waiting", smp_en, 0);
        end
        sdi = 1'b1;
        for (int k = 0; k <= 21; k++) begin
            @(posedge clk); #1;
            if (k >= 1) begin
                logic [1:0] e = exp_slot(k - 1, v);
                chk(slot_req(k - 1), $sformatf("sdo_oe slot %0d", k - 1), sdo_oe, e[1]);
                chk(slot_req(k - 1), $sformatf("sdo slot %0d", k - 1), sdo, e[0]);
            end
            chk("R4", $sformatf("smp_en after edge %0d", k), smp_en, (k == 2));
            if (k >= 3 && k <= 10)
                chk("R5", $sformatf("trial after edge %0d", k), dac_code, exp_trial(10 - k, v));
            else
                chk("R5", $sformatf("dac idle after edge %0d", k), dac_code, 0);
            if (k == abort_at) begin
                cs_n = 1'b1;
                #1;
                chk("R9", "oe drops on deselect", sdo_oe, 0);
                @(posedge clk); #1;
                chk("R9", "dac idle after abort", dac_code, 0);
                chk("R9", "strobe off after abort", smp_en, 0);
                return;
            end
            if (k == 0)      sdi = sgl;
            else if (k == 1) sdi = ch;
            else             sdi = 1'($urandom_range(0, 1)); // R10 noise
        end
        chk("R2", "mode bit captured", mux_sgl, sgl);
        chk("R10", "channel bit unaffected by noise", mux_chan, ch);
        cs_n = 1'b1;
        sdi  = 1'b0;
        #1;
        chk("R3", "oe released on deselect", sdo_oe, 0);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        cs_n  = 1'b1;
        sdi   = 1'b0;
        vin   = 8'h00;
        repeat (4) @(posedge clk);
        #1;
        chk("R1", "sdo_oe in reset", sdo_oe, 0);
        chk("R1", "sdo in reset", sdo, 0);
        chk("R1", "smp_en in reset", smp_en, 0);
        chk("R1", "dac_code in reset", dac_code, 0);
        chk("R1", "mux_sgl in reset", mux_sgl, 0);
        chk("R1", "mux_chan in reset", mux_chan, 0);
        rst_n = 1'b1;

        // Directed corner levels.
        run_conv(8'h00, 1'b1, 1'b0, 0, -1);
        run_conv(8'hFF, 1'b0, 1'b1, 2, -1);
        run_conv(8'h80, 1'b1, 1'b1, 1, -1);
        run_conv(8'h7F, 1'b0, 1'b0, 3, -1);
        run_conv(8'h55, 1'b1, 1'b0, 0, -1);
        run_conv(8'hAA, 1'b0, 1'b1, 0, -1);

        // R9: aborts in address, search, replay and trailing-low periods.
        run_conv(8'h3C, 1'b1, 1'b1, 1, 1);
        run_conv(8'hC3, 1'b0, 1'b0, 0, -1);
        run_conv(8'h96, 1'b1, 1'b0, 0, 6);
        run_conv(8'h69, 1'b1, 1'b1, 2, 15);
        run_conv(8'h5A, 1'b0, 1'b1, 0, 20);
        run_conv(8'hA5, 1'b1, 1'b0, 1, -1);

        // Random levels, address bits and lead-in lengths.
        for (int n = 0; n < 24; n++)
            run_conv(8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), $urandom_range(0, 4), -1);

        finish_run();
    end
endmodule